// File: doc/BRIEF.md
# Flash Command Sequencer with Error Status

This block sits between a CPU write port and an on-chip flash array. Software writes command words to it. Only the low byte of each word is decoded. Some commands take one bus cycle and others take two. For the two-cycle commands, the sequencer checks the second cycle, looks up the write-protect state of the addressed block, and either launches an array operation or records an error.

Program, block erase and lock-bit program operations are handed to the array on a start/done/fail handshake. While one runs, the block reports itself not ready and ignores further writes. Outcomes land in a sticky two-bit error code that software reads after the operation has ended. A global lock-disable input makes the sequencer ignore the lock table and suppresses every lock and failure error. A dedicated command clears the code.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `ready` is 1, `err_code` is 00, `cmd_pend` is 0 and `arr_start` is 0.
- R2: Writing low byte 40h and then any word starts a program operation on an unlocked block. `arr_start` pulses for exactly one cycle after the second write, with `arr_op`=01 and the second write's address and data. `ready` stays 0 from that cycle until the cycle after `arr_done`.
- R3: Writing 20h and then a word with low byte D0h starts a block erase. `arr_op`=10 and `arr_addr` holds the second write's address.
- R4: Writing FFh as the second cycle of an erase (20h) or a lock-bit program (77h) discards the command. No operation starts, `cmd_pend` returns to 0 and `err_code` is unchanged.
- R5: Any second-cycle low byte other than D0h or FFh after 20h or 77h sets `err_code` to 11 (sequence error) and starts nothing.
- R6: A first-cycle low byte that is not 40h, 20h, 77h, 50h or FFh sets `err_code` to 11.
- R7: Block index is `wr_addr[ADDR_W-1 -: BLK_W]`, and `lock_bits[i]`=1 locks block i. If `lock_off` is 0, an erase confirm to a locked block sets 10 and a program to a locked block sets 01. In both cases the code is set in the cycle after the write, nothing starts, and `ready` stays 1.
- R8: When `arr_done` arrives with `arr_fail`=1, the code becomes 10 for an erase and 01 for a program or lock-bit program. It is visible in the same cycle that `ready` returns to 1.
- R9: With `lock_off`=1, locked blocks are programmed and erased normally, and a failing operation leaves `err_code` unchanged.
- R10: While `ready` is 0, command writes are ignored, including clear-status and first-cycle codes.
- R11: A nonzero `err_code` holds its first value until a write of low byte 50h clears it to 00. New commands and later errors do not change it.
- R12: Writing 77h and then D0h starts a lock-bit program (`arr_op`=11) whatever the block's lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Write address; upper BLK_W bits select the block |
| wr_data | input | DATA_W | Write data; low byte is the command code |
| lock_bits | input | 2**BLK_W | Per-block write-protect table |
| lock_off | input | 1 | 1 ignores lock table and suppresses lock/failure errors |
| arr_done | input | 1 | Array operation finished (one-cycle pulse) |
| arr_fail | input | 1 | Valid with arr_done: operation did not complete correctly |
| arr_start | output | 1 | One-cycle launch pulse to the array |
| arr_op | output | 2 | Operation: 01 program, 10 erase, 11 lock-bit program |
| arr_addr | output | ADDR_W | Target address of the launched operation |
| arr_data | output | DATA_W | Program data of the launched operation |
| ready | output | 1 | 0 while an array operation runs |
| cmd_pend | output | 1 | 1 while the second cycle of a command is awaited |
| err_code | output | 2 | 11 sequence, 10 erase, 01 program, 00 none |

## Verification
The bench builds the sequencer with ADDR_W=10, DATA_W=16 and BLK_W=3. This gives eight blocks indexed by address bits 9:7, so a locked block in the middle of the table (block 3) and the top block (block 7) can both be addressed in a few writes. The narrow address keeps the check of `arr_addr` exact. Because the data word is wider than a byte, the bench can put nonzero upper bits on command writes and confirm that only the low byte is decoded. An array model with a fixed four-cycle latency and a selectable fail flag makes the busy window long enough to post writes into it.

// File: rtl/fseq_pkg.sv
`timescale 1ns/1ps
package fseq_pkg;
  localparam logic [7:0] CODE_PROG  = 8'h40;
  localparam logic [7:0] CODE_ERASE = 8'h20;
  localparam logic [7:0] CODE_LOCKP = 8'h77;
  localparam logic [7:0] CODE_CLR   = 8'h50;
  localparam logic [7:0] CODE_READ  = 8'hFF;
  localparam logic [7:0] CODE_CONF  = 8'hD0;

  typedef enum logic [2:0] {
    K_PROG, K_ERASE, K_LOCKP, K_CLR, K_READ, K_CONF, K_OTHER
  } cmd_kind_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00, OP_PROG = 2'b01, OP_ERASE = 2'b10, OP_LOCKP = 2'b11
  } op_t;

  typedef enum logic [1:0] {
    ERR_NONE = 2'b00, ERR_PROG = 2'b01, ERR_ERASE = 2'b10, ERR_SEQ = 2'b11
  } err_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PROG2, S_ERASE2, S_LOCKP2, S_BUSY
  } seq_state_t;
endpackage

// File: rtl/fseq_decode.sv
`timescale 1ns/1ps
module fseq_decode
  import fseq_pkg::*;
(
  input  logic [7:0] code,
  output cmd_kind_t  kind
);
  always_comb begin
    unique case (code)
      CODE_PROG:  kind = K_PROG;
      CODE_ERASE: kind = K_ERASE;
      CODE_LOCKP: kind = K_LOCKP;
      CODE_CLR:   kind = K_CLR;
      CODE_READ:  kind = K_READ;
      CODE_CONF:  kind = K_CONF;
      default:    kind = K_OTHER;
    endcase
  end
endmodule

// File: rtl/fseq_ctrl.sv
`timescale 1ns/1ps
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BLK_W  = 2,
  localparam int NBLK  = 1 << BLK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  cmd_kind_t         kind,
  input  logic [NBLK-1:0]   lock_bits,
  input  logic              lock_off,
  input  logic              arr_done,
  input  logic              arr_fail,
  output logic              start_q,
  output op_t               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              ready_q,
  output logic              pend_q,
  output logic              set_v,
  output err_t              set_c,
  output logic              clr
);
  seq_state_t        state, nxt;
  logic              go;
  op_t               go_op;
  logic [BLK_W-1:0]  blk;
  logic              blocked;

  assign blk     = wr_addr[ADDR_W-1 -: BLK_W];
  assign blocked = lock_bits[blk] & ~lock_off;

  always_comb begin
    nxt   = state;
    go    = 1'b0;
    go_op = op_q;
    set_v = 1'b0;
    set_c = ERR_NONE;
    clr   = 1'b0;
    case (state)
      S_IDLE: if (wr_en) begin
        case (kind)
          K_PROG:  nxt = S_PROG2;
          K_ERASE: nxt = S_ERASE2;
          K_LOCKP: nxt = S_LOCKP2;
          K_CLR:   clr = 1'b1;
          K_READ:  nxt = S_IDLE;
          default: begin set_v = 1'b1; set_c = ERR_SEQ; end
        endcase
      end
      S_PROG2: if (wr_en) begin
        nxt = S_IDLE;
        if (blocked) begin
          set_v = 1'b1; set_c = ERR_PROG;
        end else begin
          go = 1'b1; go_op = OP_PROG; nxt = S_BUSY;
        end
      end
      S_ERASE2: if (wr_en) begin
        nxt = S_IDLE;
        if (kind == K_CONF) begin
          if (blocked) begin
            set_v = 1'b1; set_c = ERR_ERASE;
          end else begin
            go = 1'b1; go_op = OP_ERASE; nxt = S_BUSY;
          end
        end else if (kind != K_READ) begin
          set_v = 1'b1; set_c = ERR_SEQ;
        end
      end
      S_LOCKP2: if (wr_en) begin
        nxt = S_IDLE;
        if (kind == K_CONF) begin
          go = 1'b1; go_op = OP_LOCKP; nxt = S_BUSY;
        end else if (kind != K_READ) begin
          set_v = 1'b1; set_c = ERR_SEQ;
        end
      end
      S_BUSY: if (arr_done) begin
        nxt = S_IDLE;
        if (arr_fail && !lock_off) begin
          set_v = 1'b1;
          set_c = (op_q == OP_ERASE) ? ERR_ERASE : ERR_PROG;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      start_q <= 1'b0;
      op_q    <= OP_NONE;
      addr_q  <= '0;
      data_q  <= '0;
      ready_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      state   <= nxt;
      start_q <= go;
      ready_q <= (nxt != S_BUSY);
      pend_q  <= (nxt == S_PROG2) || (nxt == S_ERASE2) || (nxt == S_LOCKP2);
      if (go) begin
        op_q   <= go_op;
        addr_q <= wr_addr;
        data_q <= wr_data;
      end
    end
  end
endmodule

// File: rtl/fseq_status.sv
`timescale 1ns/1ps
module fseq_status
  import fseq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_v,
  input  err_t set_c,
  input  logic clr,
  output err_t err_q
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      err_q <= ERR_NONE;
    else if (set_v && err_q == ERR_NONE)
      err_q <= set_c;
  end
endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BLK_W  = 2,
  localparam int NBLK  = 1 << BLK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NBLK-1:0]   lock_bits,
  input  logic              lock_off,
  input  logic              arr_done,
  input  logic              arr_fail,
  output logic              arr_start,
  output logic [1:0]        arr_op,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              ready,
  output logic              cmd_pend,
  output logic [1:0]        err_code
);
  cmd_kind_t kind;
  op_t       op_q;
  err_t      set_c, err_q;
  logic      set_v, clr;

  fseq_decode u_dec (
    .code (wr_data[7:0]),
    .kind (kind)
  );

  fseq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .kind      (kind),
    .lock_bits (lock_bits),
    .lock_off  (lock_off),
    .arr_done  (arr_done),
    .arr_fail  (arr_fail),
    .start_q   (arr_start),
    .op_q      (op_q),
    .addr_q    (arr_addr),
    .data_q    (arr_data),
    .ready_q   (ready),
    .pend_q    (cmd_pend),
    .set_v     (set_v),
    .set_c     (set_c),
    .clr       (clr)
  );

  fseq_status u_stat (
    .clk   (clk),
    .rst   (rst),
    .set_v (set_v),
    .set_c (set_c),
    .clr   (clr),
    .err_q (err_q)
  );

  assign arr_op   = op_q;
  assign err_code = err_q;
endmodule

// File: rtl/fseq_checker.sv
`timescale 1ns/1ps
module fseq_checker #(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 2,
  localparam int NBLK  = 1 << BLK_W
) (
  input logic              clk,
  input logic              rst,
  input logic [NBLK-1:0]   lock_bits,
  input logic              lock_off,
  input logic              arr_done,
  input logic              arr_fail,
  input logic              arr_start,
  input logic [1:0]        arr_op,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              ready,
  input logic [1:0]        err_code
);
  logic            pv;
  logic [NBLK-1:0] lock_q;
  logic            lock_off_q;
  logic [1:0]      err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv <= 1'b0; lock_q <= '0; lock_off_q <= 1'b0; err_q <= 2'b00;
    end else begin
      pv <= 1'b1; lock_q <= lock_bits; lock_off_q <= lock_off; err_q <= err_code;
    end
  end

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    arr_start |=> !arr_start);

  assert_start_busy_R10: assert property (@(posedge clk) disable iff (rst)
    arr_start |-> !ready);

  assert_lock_honored_R7: assert property (@(posedge clk) disable iff (rst)
    (pv && arr_start && arr_op != 2'b11 && !lock_off_q)
      |-> !lock_q[arr_addr[ADDR_W-1 -: BLK_W]]);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (pv && err_code != err_q) |-> (err_q == 2'b00 || err_code == 2'b00));

  assert_lockoff_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (pv && !ready && arr_done && arr_fail && lock_off) |=> $stable(err_code));
endmodule

bind flash_cmd_seq fseq_checker #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .lock_bits (lock_bits),
  .lock_off  (lock_off),
  .arr_done  (arr_done),
  .arr_fail  (arr_fail),
  .arr_start (arr_start),
  .arr_op    (arr_op),
  .arr_addr  (arr_addr),
  .ready     (ready),
  .err_code  (err_code)
);

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;
  localparam int AW = 10, DW = 16, BW = 3, NB = 1 << BW, LAT = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NB-1:0] lock_bits = '0;
  logic lock_off = 1'b0, arr_done = 1'b0, arr_fail = 1'b0;
  logic arr_start, ready, cmd_pend;
  logic [1:0] arr_op, err_code;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;

  int total = 0, bad = 0, cnt = 0;
  logic fail_next = 1'b0, ended = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .BLK_W(BW)) i_flash_cmd_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lock_bits(lock_bits), .lock_off(lock_off), .arr_done(arr_done),
    .arr_fail(arr_fail), .arr_start(arr_start), .arr_op(arr_op),
    .arr_addr(arr_addr), .arr_data(arr_data), .ready(ready),
    .cmd_pend(cmd_pend), .err_code(err_code));

  // behavioural array: done pulse LAT cycles after a start
  always @(negedge clk) begin
    arr_done <= 1'b0;
    arr_fail <= 1'b0;
    if (rst) cnt = 0;
    else if (cnt != 0) begin
      cnt = cnt - 1;
      if (cnt == 0) begin arr_done <= 1'b1; arr_fail <= fail_next; end
    end else if (arr_start) cnt = LAT;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ready(input string tag);
    for (int i = 0; i < 40 && !ready; i++) @(negedge clk);
    chk(tag, ready, 1);
  endtask

  task automatic clear_err();
    wr(0, 16'h0050);
    chk("R11 clear", err_code, 0);
  endtask

  task t_reset();
    chk("R1 ready", ready, 1);
    chk("R1 err", err_code, 0);
    chk("R1 pend", cmd_pend, 0);
    chk("R1 start", arr_start, 0);
  endtask

  task t_program();
    wr(0, 16'hAB40);
    chk("R2 pend", cmd_pend, 1);
    wr(10'h1A5, 16'h3C55);
    chk("R2 start", arr_start, 1);
    chk("R2 op", arr_op, 1);
    chk("R2 addr", arr_addr, 10'h1A5);
    chk("R2 data", arr_data, 16'h3C55);
    chk("R2 busy", ready, 0);
    @(negedge clk);
    chk("R2 pulse", arr_start, 0);
    wait_ready("R2 done");
    chk("R2 err", err_code, 0);
  endtask

  task t_erase();
    wr(0, 16'h0020);
    wr(10'h300, 16'h12D0);
    chk("R3 start", arr_start, 1);
    chk("R3 op", arr_op, 2);
    chk("R3 addr", arr_addr, 10'h300);
    wait_ready("R3 done");
    chk("R3 err", err_code, 0);
  endtask

  task t_abort();
    wr(0, 16'h0020);
    wr(10'h100, 16'h00FF);
    chk("R4 erase start", arr_start, 0);
    chk("R4 erase pend", cmd_pend, 0);
    chk("R4 erase err", err_code, 0);
    wr(0, 16'h0077);
    wr(10'h100, 16'h55FF);
    chk("R4 lockp start", arr_start, 0);
    chk("R4 lockp ready", ready, 1);
    chk("R4 lockp err", err_code, 0);
  endtask

  task t_badconf();
    wr(0, 16'h0020);
    wr(10'h100, 16'h0055);
    chk("R5 err", err_code, 3);
    chk("R5 start", arr_start, 0);
    chk("R5 pend", cmd_pend, 0);
    clear_err();
    wr(0, 16'h0077);
    wr(10'h100, 16'h0040);
    chk("R5 lockp err", err_code, 3);
    clear_err();
  endtask

  task t_badfirst();
    wr(0, 16'h0012);
    chk("R6 err", err_code, 3);
    wr(0, 16'h0040);
    wr(10'h010, 16'h0001);
    wait_ready("R11 op after err");
    chk("R11 kept by new cmd", err_code, 3);
    clear_err();
    wr(0, 16'h00D0);
    chk("R6 bare confirm", err_code, 3);
    clear_err();
  endtask

  task t_lock();
    lock_bits = 8'b1000_1000;
    wr(0, 16'h0020);
    wr(10'h180, 16'h00D0);
    chk("R7 erase err", err_code, 2);
    chk("R7 erase start", arr_start, 0);
    chk("R7 erase ready", ready, 1);
    wr(0, 16'h0040);
    wr(10'h3F0, 16'h1234);
    chk("R11 first held", err_code, 2);
    clear_err();
    wr(0, 16'h0040);
    wr(10'h3F0, 16'h1234);
    chk("R7 prog top block err", err_code, 1);
    chk("R7 prog start", arr_start, 0);
    clear_err();
    wr(0, 16'h0040);
    wr(10'h200, 16'h1234);
    chk("R7 unlocked neighbour", arr_start, 1);
    wait_ready("R7 neighbour done");
    chk("R7 neighbour err", err_code, 0);
    wr(0, 16'h0077);
    wr(10'h180, 16'h00D0);
    chk("R12 start", arr_start, 1);
    chk("R12 op", arr_op, 3);
    wait_ready("R12 done");
    chk("R12 err", err_code, 0);
    lock_bits = '0;
  endtask

  task t_fail();
    fail_next = 1'b1;
    wr(0, 16'h0020);
    wr(10'h080, 16'h00D0);
    @(negedge clk);
    chk("R8 err held during busy", err_code, 0);
    wait_ready("R8 erase done");
    chk("R8 erase fail", err_code, 2);
    clear_err();
    wr(0, 16'h0040);
    wr(10'h081, 16'h0F0F);
    wait_ready("R8 prog done");
    chk("R8 prog fail", err_code, 1);
    clear_err();
    wr(0, 16'h0077);
    wr(10'h082, 16'h00D0);
    wait_ready("R8 lockp done");
    chk("R8 lockp fail", err_code, 1);
    clear_err();
    fail_next = 1'b0;
  endtask

  task t_lockoff();
    lock_off = 1'b1;
    lock_bits = 8'b0000_1000;
    wr(0, 16'h0020);
    wr(10'h180, 16'h00D0);
    chk("R9 erase starts", arr_start, 1);
    wait_ready("R9 done");
    chk("R9 err", err_code, 0);
    fail_next = 1'b1;
    wr(0, 16'h0040);
    wr(10'h180, 16'h0001);
    chk("R9 prog starts", arr_start, 1);
    wait_ready("R9 fail done");
    chk("R9 fail quiet", err_code, 0);
    fail_next = 1'b0;
    lock_off = 1'b0;
    lock_bits = '0;
  endtask

  task t_busy();
    lock_bits = 8'b0000_0001;
    wr(0, 16'h0040);
    wr(10'h000, 16'h0001);
    chk("R10 setup err", err_code, 1);
    wr(0, 16'h0040);
    wr(10'h380, 16'h0002);
    chk("R10 started", arr_start, 1);
    wr(0, 16'h0050);
    chk("R10 clear ignored", err_code, 1);
    wr(0, 16'h0020);
    chk("R10 no pend", cmd_pend, 0);
    wait_ready("R10 done");
    chk("R10 err after", err_code, 1);
    chk("R10 pend after", cmd_pend, 0);
    clear_err();
    lock_bits = '0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_program();
    t_erase();
    t_abort();
    t_badconf();
    t_badfirst();
    t_lock();
    t_fail();
    t_lockoff();
    t_busy();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule